// File: doc/BRIEF.md
# Move-Bus Destination Redirect

This block forms the destination side of an 8-bit machine whose only instruction is a move from one address to another. A decoder outside the block supplies the destination address and the data on the bus. The block works out the effective destination and raises one write strobe for it. Most destinations pass straight through. One reserved address is indirect: a move aimed at it goes to whichever address a small pointer register holds. The pointer is loaded by an ordinary move to its own fixed address.

The choice between direct and indirect is made by a multiplexer alone, so every instruction still takes two clocks. The first clock reads and the second writes. The block also holds a few registers at the lowest addresses so that the writes can be seen. Address $00 is a sink that keeps nothing, and address $01 holds the low byte of the program counter. A conditional branch is built in two moves. First a 0/1 compare flag is moved into the pointer. Then the branch target is moved to the indirect address. The target either falls into the sink or loads the program counter.

Top module: `moveRedirTop`

## Requirements
- R1: After reset the pointer register reads $00, every observed low register reads zero, no write strobe is asserted and the first clock is a read clock (wrPhase = 0).
- R2: wrPhase alternates on every clock: 0 in the read clock and 1 in the write clock of each two-clock instruction. No strobe is asserted while wrPhase is 0.
- R3: A destination other than the indirect address $FF appears unchanged on effAddr, in both clocks, with no added cycle.
- R4: A destination of $FF yields effAddr equal to the pointer value, unless the pointer holds $FF.
- R5: If the pointer holds $FF, a move to $FF is not redirected again and its effective address is the sink $00.
- R6: In the write clock exactly one bit of wrStrobe is set, and that bit is the one whose index equals effAddr.
- R7: A move whose effective address is $FE loads busData into the pointer at the end of the write clock. No other move changes the pointer.
- R8: A write to $00 has no effect. The sink always reads zero and no other observed register changes.
- R9: A move whose effective address is $01, direct or redirected, loads busData into the program-counter low byte (regView bits 15:8).
- R10: After a 0/1 flag is moved to $FE, a move of a target to $FF leaves the program counter unchanged for flag 0 and loads it with the target for flag 1.
- R11: A move whose effective address is an observed register k (1 to NUM_REGS-1) updates regView bits 8k+7:8k and no other observed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dstAddr | input | 8 | Decoded destination address, held for both clocks of an instruction |
| busData | input | 8 | Data on the move bus, held for both clocks |
| effAddr | output | 8 | Effective destination after redirection |
| wrPhase | output | 1 | 1 during the write clock of an instruction |
| wrStrobe | output | 256 | One-hot write strobe per destination, set only in the write clock |
| ptrValue | output | 8 | Current pointer register contents |
| regView | output | 32 | Observed low registers, register k in bits 8k+7:8k |

## Verification
The bench aims at the pointer corners. These are: a pointer that holds the indirect address, which a careless design would redirect again to $FF or would strobe twice; a redirected write to the pointer's own address, which must reload the pointer; and writes to the sink, which a wrong design would store or pass on to a neighbour. It runs the branch idiom with both flag values, because a design that inverts or ignores the flag would jump when it should fall through. It also checks that strobes stay low in the read clock, which an off-by-one phase counter would break by writing a clock early. Random moves mixed over the special addresses catch a stale pointer or a strobe placed at the raw destination rather than at the effective one.

// File: rtl/moveRedirPkg.sv
package moveRedirPkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  // strobes passed from control to datapath
  typedef struct packed {
    logic writeEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/moveRedirCtrl.sv
module moveRedirCtrl
  import moveRedirPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t ctrl,
  output logic         wrPhase
);
  logic phaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= 1'b0;
    else       phaseQ <= ~phaseQ;
  end

  assign wrPhase      = phaseQ;
  assign ctrl.writeEn = phaseQ;

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (wrPhase != $past(wrPhase)));  // R2
endmodule

// File: rtl/moveRedirDatapath.sv
module moveRedirDatapath
  import moveRedirPkg::*;
#(
  parameter int                 NUM_REGS      = 4,
  parameter logic [ADDR_W-1:0]  PTR_ADDR      = 8'hFE,
  parameter logic [ADDR_W-1:0]  PTR_DATA_ADDR = 8'hFF,
  parameter logic [ADDR_W-1:0]  SINK_ADDR     = 8'h00
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               ctrl,
  input  logic [ADDR_W-1:0]          dstAddr,
  input  logic [DATA_W-1:0]          busData,
  output logic [ADDR_W-1:0]          effAddr,
  output logic [(1<<ADDR_W)-1:0]     wrStrobe,
  output logic [ADDR_W-1:0]          ptrValue,
  output logic [NUM_REGS*DATA_W-1:0] regView
);
  localparam int NUM_DEST = 1 << ADDR_W;

  logic [ADDR_W-1:0] ptrQ;
  logic              isIndirect;

  // redirect mux: no register on this path
  assign isIndirect = (dstAddr == PTR_DATA_ADDR);
  always_comb begin
    if (!isIndirect)                 effAddr = dstAddr;
    else if (ptrQ == PTR_DATA_ADDR)  effAddr = SINK_ADDR;
    else                             effAddr = ptrQ;
  end

  // one-hot decode of the effective destination
  for (genvar a = 0; a < NUM_DEST; a++) begin : g_strobe
    assign wrStrobe[a] = ctrl.writeEn && (effAddr == ADDR_W'(a));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      ptrQ <= '0;
    else if (wrStrobe[PTR_ADDR])    ptrQ <= busData;
  end
  assign ptrValue = ptrQ;

  // observed low registers; the sink keeps nothing
  assign regView[DATA_W-1:0] = '0;
  for (genvar k = 1; k < NUM_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] regQ;
    always_ff @(posedge clk) begin
      if (!rstN)            regQ <= '0;
      else if (wrStrobe[k]) regQ <= busData;
    end
    assign regView[k*DATA_W +: DATA_W] = regQ;
  end

  AST_STROBE_QUIET_READ: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.writeEn |-> (wrStrobe == '0));  // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.writeEn |-> ($countones(wrStrobe) == 1));  // R6
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (dstAddr != PTR_DATA_ADDR) |-> (effAddr == dstAddr));  // R3
  AST_NO_DOUBLE_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (dstAddr == PTR_DATA_ADDR) |-> (effAddr != PTR_DATA_ADDR));  // R5
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.writeEn && effAddr == PTR_ADDR) |=> (ptrQ == $past(busData)));  // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.writeEn && effAddr == PTR_ADDR) |=> $stable(ptrQ));  // R7
  AST_SINK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (regView[DATA_W-1:0] == '0));  // R8
endmodule

// File: rtl/moveRedirTop.sv
module moveRedirTop
  import moveRedirPkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [7:0]                 dstAddr,
  input  logic [7:0]                 busData,
  output logic [7:0]                 effAddr,
  output logic                       wrPhase,
  output logic [255:0]               wrStrobe,
  output logic [7:0]                 ptrValue,
  output logic [NUM_REGS*8-1:0]      regView
);
  ctrlStrobes_t ctrl;

  moveRedirCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .wrPhase (wrPhase)
  );

  moveRedirDatapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dstAddr  (dstAddr),
    .busData  (busData),
    .effAddr  (effAddr),
    .wrStrobe (wrStrobe),
    .ptrValue (ptrValue),
    .regView  (regView)
  );
endmodule

// File: tb/sim_moveRedirTop.sv
module sim_moveRedirTop;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] dstAddr = '0;
  logic [7:0] busData = '0;
  logic [7:0] effAddr;
  logic wrPhase;
  logic [255:0] wrStrobe;
  logic [7:0] ptrValue;
  logic [NREG*8-1:0] regView;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mPtr;
  logic [7:0] mReg [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  moveRedirTop #(.NUM_REGS(NREG)) u0 (
    .clk(clk), .rstN(rstN), .dstAddr(dstAddr), .busData(busData),
    .effAddr(effAddr), .wrPhase(wrPhase), .wrStrobe(wrStrobe),
    .ptrValue(ptrValue), .regView(regView)
  );

  function automatic logic [7:0] expEff(logic [7:0] d, logic [7:0] p);
    if (d != 8'hFF) return d;
    if (p == 8'hFF) return 8'h00;
    return p;
  endfunction

  function automatic logic [255:0] expStrobe(logic [7:0] e, bit wr);
    logic [255:0] v = '0;
    if (wr) v[e] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    chk({req, " ptr"}, 256'(ptrValue), 256'(mPtr));
    for (int k = 0; k < NREG; k++)
      chk({req, " reg"}, 256'(regView[k*8 +: 8]), 256'(mReg[k]));
  endtask

  // one two-clock move; entered at a negedge in the read clock
  task automatic doMove(logic [7:0] d, logic [7:0] v, string req);
    logic [7:0] e;
    e = expEff(d, mPtr);
    dstAddr = d;
    busData = v;
    #1;
    chk({req, " R2 read phase"}, 256'(wrPhase), 256'(0));
    chk({req, " R3/R4/R5 eff read clk"}, 256'(effAddr), 256'(e));
    chk({req, " R2 no strobe in read"}, wrStrobe, '0);
    @(negedge clk);
    chk({req, " R2 write phase"}, 256'(wrPhase), 256'(1));
    chk({req, " R3/R4/R5 eff write clk"}, 256'(effAddr), 256'(e));
    chk({req, " R6 strobe"}, wrStrobe, expStrobe(e, 1'b1));
    @(negedge clk);
    if (e == 8'hFE) mPtr = v;
    if (e != 8'h00 && e < NREG) mReg[e] = v;
    checkState({req, " R7/R8/R9/R11 state"});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [7:0] d;
    logic [7:0] pcBefore;
    seed = $urandom(32'h5EED_1234);
    mPtr = '0;
    for (int k = 0; k < NREG; k++) mReg[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 phase", 256'(wrPhase), 256'(0));
    chk("R1 strobe", wrStrobe, '0);
    checkState("R1");

    // R8: sink write
    doMove(8'h00, 8'hA5, "R8 sink");
    // R11: plain register
    doMove(8'h02, 8'h3C, "R11 reg2");
    doMove(8'h03, 8'hC3, "R11 reg3");
    // R9: direct PC write
    doMove(8'h01, 8'h40, "R9 pc direct");
    // R4 with reset pointer $00 -> sink
    doMove(8'hFF, 8'h77, "R4 ptr zero");
    // R7/R4 pointer to reg2, redirected write
    doMove(8'hFE, 8'h02, "R7 ptr load");
    doMove(8'hFF, 8'h99, "R4 redirect reg2");
    // R9 redirected PC write
    doMove(8'hFE, 8'h01, "R7 ptr pc");
    doMove(8'hFF, 8'h12, "R9 pc redirect");
    // R10: branch idiom, flag 0 then flag 1
    doMove(8'hFE, 8'h00, "R10 flag0");
    pcBefore = mReg[1];
    doMove(8'hFF, 8'h80, "R10 not taken");
    chk("R10 pc unchanged", 256'(regView[15:8]), 256'(pcBefore));
    doMove(8'hFE, 8'h01, "R10 flag1");
    doMove(8'hFF, 8'h81, "R10 taken");
    chk("R10 pc loaded", 256'(regView[15:8]), 256'(8'h81));
    // R5: pointer holds the indirect address
    doMove(8'hFE, 8'hFF, "R5 ptr ff");
    doMove(8'hFF, 8'h55, "R5 no double redirect");
    // redirected write to the pointer's own address reloads it
    doMove(8'hFE, 8'hFE, "R7 ptr self");
    doMove(8'hFF, 8'h03, "R7 redirect reload");
    doMove(8'hFF, 8'h5A, "R11 via new ptr");

    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 8)
        0: d = 8'h00;
        1: d = 8'h01;
        2: d = 8'h02;
        3: d = 8'h03;
        4: d = 8'hFE;
        5: d = 8'hFF;
        default: d = 8'($urandom);
      endcase
      doMove(d, 8'($urandom), "RND R3 R4 R6");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule